// File: doc/BRIEF.md
# Shadowed Screen Write-Through Address Decoder

This block sits between a 32-bit CPU request/acknowledge bus and four kinds of memory targets. A 24-bit byte address is sorted into one of three fast 32-bit RAM banks of 4 MB each, a 2 MB flash area, or an alias window that forwards accesses to an older 8-bit peripheral bus. Each target has its own select line and its own acknowledge line. The RAM and flash share one address, write-enable, byte-enable and write-data bundle.

A small part of the low RAM range mirrors the legacy display memory. Reads there come from fast RAM alone, which keeps them quick. Writes there update fast RAM first. The same data is then replayed onto the 8-bit bus as one byte cycle for each enabled lane, so the old display hardware stays in step. The CPU is not acknowledged until the last byte cycle has finished.

Accesses through the alias window are also split into byte cycles on the 8-bit bus. On a read, the returned bytes are gathered back into their 32-bit lanes. A request that names no target, or that carries no byte enable, ends with a bus-error pulse instead of an acknowledge.

Top module: `screen_shadow_decoder`

## Requirements
- R1: While reset is held and after its release with no request, `ram_sel`, `flash_sel`, `leg_strb`, `cpu_ack` and `cpu_berr` are all low.
- R2: Addresses 0x000000 to 0xBFFFFF go to fast RAM. `ram_sel` is one-hot, with bit n set for bank n = addr[23:22]. `mem_addr` carries addr[21:2].
- R3: Addresses 0xC00000 to 0xDFFFFF raise `flash_sel` and no other target select. `mem_addr` carries addr[21:2].
- R4: Addresses 0xE00000 to 0xFFFFFF go to the 8-bit bus as byte cycles with `leg_addr` = {addr[19:2], byte offset}. On a read, each returned byte lands in its own lane of `cpu_rdata`, and lanes that are not enabled read as zero.
- R5: A read in the screen window 0x020000 to 0x027FFF uses one fast-RAM read, returns the RAM word, and produces no `leg_strb`.
- R6: A write in the screen window performs the fast-RAM write first. It then performs one legacy byte write per enabled lane, with `leg_addr` = {addr[19:2], offset}.
- R7: Lane encoding is big-endian. `cpu_be[3]` is byte offset 0 and carries `cpu_wdata[31:24]`; `cpu_be[0]` is offset 3 and carries `cpu_wdata[7:0]`. Byte cycles are issued in ascending offset order.
- R8: Each byte cycle keeps `leg_strb` high, with `leg_addr` unchanged, until `leg_ack`. The cycle after an acknowledged byte has `leg_strb` low.
- R9: A screen-window write is acknowledged only after its last legacy byte cycle has been acknowledged. Every access ends in exactly one cycle of `cpu_ack` or `cpu_berr`.
- R10: RAM writes outside the screen window, including the addresses just outside it (0x01FFFC and 0x028000), produce no legacy byte cycle.
- R11: A request with `cpu_be` = 0, or whose bank index is at or above the populated bank count, gets one cycle of `cpu_berr`, no `cpu_ack`, and no target select.
- R12: `cpu_ack` and `cpu_berr` are never high together, and at most one of RAM, flash or legacy strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request, held until acknowledge or bus error |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | CPU byte address |
| cpu_be | input | 4 | Byte enables, bit 3 = offset 0 |
| cpu_wdata | input | 32 | Write data, big-endian lanes |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_berr | output | 1 | One-cycle bus-error pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_addr | output | 20 | Word address for RAM and flash |
| mem_we | output | 1 | Write enable for RAM and flash |
| mem_be | output | 4 | Byte enables for RAM and flash |
| mem_wdata | output | 32 | Write data for RAM and flash |
| ram_sel | output | 3 | One-hot RAM bank select |
| ram_ack | input | 1 | RAM access complete |
| ram_rdata | input | 32 | RAM read data |
| flash_sel | output | 1 | Flash select |
| flash_ack | input | 1 | Flash access complete |
| flash_rdata | input | 32 | Flash read data |
| leg_strb | output | 1 | Legacy byte-cycle strobe |
| leg_we | output | 1 | Legacy byte-cycle direction |
| leg_addr | output | 20 | Legacy byte address |
| leg_wdata | output | 8 | Legacy write byte |
| leg_ack | input | 1 | Legacy byte cycle complete |
| leg_rdata | input | 8 | Legacy read byte |

## Verification
The bench targets the edges of the screen window: its first and last words, and the words just below and just above it. A decoder with an off-by-one bound would either mirror a plain RAM write onto the slow bus or fail to mirror a real screen write. Sparse byte-enable patterns, such as 0110 and 1001, exercise the lane order and the byte steering. A reversed lane order or a wrong data slice would show up as byte cycles with the wrong offset or the wrong data. The bench also checks that the CPU acknowledge comes after the last byte cycle, which catches an acknowledge raised as soon as the RAM write ends. Finally, it checks that an empty byte-enable mask produces a bus error, which catches a design that would select a target anyway.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;

  typedef enum logic [1:0] {
    RGN_RAM   = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_LEG   = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RAM  = 2'd1,
    S_LEG  = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;

  // Byte-enable vector (bit 3 = offset 0) to a mask indexed by byte offset.
  function automatic logic [3:0] lane_mask(input logic [3:0] be);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[k] = be[3-k];
    return m;
  endfunction

  // Lowest set offset in a mask (ascending address order).
  function automatic logic [1:0] first_lane(input logic [3:0] m);
    logic [1:0] idx;
    idx = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (m[k]) idx = 2'(k);
    end
    return idx;
  endfunction

endpackage

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANK_AW   = 22,
  parameter int RAM_BANKS = 3,
  parameter int SCR_LO    = 'h020000,
  parameter int SCR_HI    = 'h027FFF
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           be,
  output region_e              region,
  output logic [RAM_BANKS-1:0] bank_oh,
  output logic                 in_screen
);

  localparam int TOPW = ADDR_W - BANK_AW;
  localparam logic [TOPW:0]       NBANKS = (TOPW+1)'(RAM_BANKS);
  localparam logic [ADDR_W-1:0]   LO     = ADDR_W'(SCR_LO);
  localparam logic [ADDR_W-1:0]   HI     = ADDR_W'(SCR_HI);

  logic [TOPW-1:0] top;
  logic [2:0]      top3;

  assign top  = addr[ADDR_W-1:BANK_AW];
  assign top3 = addr[ADDR_W-1:ADDR_W-3];

  always_comb begin
    if (be == 4'b0000)               region = RGN_NONE;
    else if ({1'b0, top} < NBANKS)   region = RGN_RAM;
    else if (top3 == 3'b110)         region = RGN_FLASH;
    else if (top3 == 3'b111)         region = RGN_LEG;
    else                             region = RGN_NONE;
  end

  for (genvar i = 0; i < RAM_BANKS; i++) begin : g_bank
    assign bank_oh[i] = (region == RGN_RAM) && (top == TOPW'(i));
  end

  assign in_screen = (addr >= LO) && (addr <= HI);

endmodule

// File: rtl/shadow_seq.sv
module shadow_seq
  import shadow_dec_pkg::*;
#(
  parameter int RAM_BANKS = 3,
  parameter int WAW       = 20,
  parameter int LEG_AW    = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [WAW-1:0]       cpu_waddr,
  input  logic [3:0]           cpu_be,
  input  logic [31:0]          cpu_wdata,
  input  region_e              dec_region,
  input  logic [RAM_BANKS-1:0] dec_bank,
  input  logic                 dec_screen,
  output logic                 cpu_ack,
  output logic                 cpu_berr,
  output logic [31:0]          cpu_rdata,
  output logic [WAW-1:0]       mem_addr,
  output logic                 mem_we,
  output logic [3:0]           mem_be,
  output logic [31:0]          mem_wdata,
  output logic [RAM_BANKS-1:0] ram_sel,
  input  logic                 ram_ack,
  input  logic [31:0]          ram_rdata,
  output logic                 flash_sel,
  input  logic                 flash_ack,
  input  logic [31:0]          flash_rdata,
  output logic                 leg_strb,
  output logic                 leg_we,
  output logic [LEG_AW-1:0]    leg_addr,
  output logic [7:0]           leg_wdata,
  input  logic                 leg_ack,
  input  logic [7:0]           leg_rdata
);

  seq_state_e           state, state_d;
  logic [3:0]           pend, pend_d, pend_left;
  logic                 gap, gap_d;
  logic                 cap_ld, rd_clr, rd_word_ld, rd_byte_ld;
  logic [WAW-1:0]       cap_waddr;
  logic                 cap_we, cap_screen;
  logic [3:0]           cap_be;
  logic [31:0]          cap_wdata, rdata;
  region_e              cap_region;
  logic [RAM_BANKS-1:0] cap_bank;
  logic [1:0]           lane, nlane;
  logic                 mem_ack;
  logic [31:0]          mem_rdata;

  assign lane      = first_lane(pend);
  assign nlane     = ~lane;
  assign pend_left = pend & ~(4'b0001 << lane);
  assign mem_ack   = (cap_region == RGN_RAM) ? ram_ack : flash_ack;
  assign mem_rdata = (cap_region == RGN_RAM) ? ram_rdata : flash_rdata;

  // Next-state logic
  always_comb begin
    state_d    = state;
    pend_d     = pend;
    gap_d      = 1'b0;
    cap_ld     = 1'b0;
    rd_clr     = 1'b0;
    rd_word_ld = 1'b0;
    rd_byte_ld = 1'b0;
    case (state)
      S_IDLE: begin
        if (cpu_req) begin
          cap_ld = 1'b1;
          rd_clr = 1'b1;
          if (dec_region == RGN_NONE) begin
            state_d = S_DONE;
          end else if (dec_region == RGN_LEG) begin
            state_d = S_LEG;
            pend_d  = lane_mask(cpu_be);
          end else begin
            state_d = S_RAM;
          end
        end
      end
      S_RAM: begin
        if (mem_ack) begin
          rd_word_ld = !cap_we;
          if (cap_we && cap_screen && (cap_region == RGN_RAM)) begin
            state_d = S_LEG;
            pend_d  = lane_mask(cap_be);
          end else begin
            state_d = S_DONE;
          end
        end
      end
      S_LEG: begin
        if (!gap && leg_ack) begin
          rd_byte_ld = !cap_we;
          pend_d     = pend_left;
          gap_d      = 1'b1;
          if (pend_left == 4'b0000) state_d = S_DONE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pend       <= 4'b0000;
      gap        <= 1'b0;
      cap_region <= RGN_NONE;
    end else begin
      state <= state_d;
      pend  <= pend_d;
      gap   <= gap_d;
      if (cap_ld) cap_region <= dec_region;
    end
  end

  // Datapath registers, loaded under enables
  always_ff @(posedge clk) begin
    if (cap_ld) begin
      cap_waddr  <= cpu_waddr;
      cap_we     <= cpu_we;
      cap_be     <= cpu_be;
      cap_wdata  <= cpu_wdata;
      cap_bank   <= dec_bank;
      cap_screen <= dec_screen;
    end
    if (rd_clr)          rdata <= 32'h0;
    else if (rd_word_ld) rdata <= mem_rdata;
    else if (rd_byte_ld) rdata[{nlane, 3'b000} +: 8] <= leg_rdata;
  end

  assign cpu_ack   = (state == S_DONE) && (cap_region != RGN_NONE);
  assign cpu_berr  = (state == S_DONE) && (cap_region == RGN_NONE);
  assign cpu_rdata = rdata;
  assign mem_addr  = cap_waddr;
  assign mem_we    = cap_we;
  assign mem_be    = cap_be;
  assign mem_wdata = cap_wdata;
  assign ram_sel   = ((state == S_RAM) && (cap_region == RGN_RAM)) ? cap_bank : '0;
  assign flash_sel = (state == S_RAM) && (cap_region == RGN_FLASH);
  assign leg_strb  = (state == S_LEG) && !gap;
  assign leg_we    = cap_we;
  assign leg_addr  = {cap_waddr[LEG_AW-3:0], lane};
  assign leg_wdata = cap_wdata[{nlane, 3'b000} +: 8];

  // Assertions
  assert_ack_berr_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack && cpu_berr));
  assert_one_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|ram_sel, flash_sel, leg_strb}));
  assert_strb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_strb && !leg_ack) |=> (leg_strb && $stable(leg_addr)));
  assert_strb_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_strb && leg_ack) |=> !leg_strb);
  assert_no_leg_unless_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    leg_strb |-> ((cap_region == RGN_LEG) || (cap_we && cap_screen)));
  assert_shadow_read_ram_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_strb && (cap_region == RGN_RAM)) |-> cap_we);
  assert_ack_after_leg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cap_we && cap_screen && (cap_region == RGN_RAM)) |-> $past(leg_ack));
  assert_berr_no_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_berr |-> (!(|ram_sel) && !flash_sel && !leg_strb));

endmodule

// File: rtl/screen_shadow_decoder.sv
module screen_shadow_decoder
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BANK_AW   = 22,
  parameter int RAM_BANKS = 3,
  parameter int LEG_AW    = 20,
  parameter int SCR_LO    = 'h020000,
  parameter int SCR_HI    = 'h027FFF,
  localparam int WAW      = BANK_AW - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [3:0]           cpu_be,
  input  logic [31:0]          cpu_wdata,
  output logic                 cpu_ack,
  output logic                 cpu_berr,
  output logic [31:0]          cpu_rdata,
  output logic [WAW-1:0]       mem_addr,
  output logic                 mem_we,
  output logic [3:0]           mem_be,
  output logic [31:0]          mem_wdata,
  output logic [RAM_BANKS-1:0] ram_sel,
  input  logic                 ram_ack,
  input  logic [31:0]          ram_rdata,
  output logic                 flash_sel,
  input  logic                 flash_ack,
  input  logic [31:0]          flash_rdata,
  output logic                 leg_strb,
  output logic                 leg_we,
  output logic [LEG_AW-1:0]    leg_addr,
  output logic [7:0]           leg_wdata,
  input  logic                 leg_ack,
  input  logic [7:0]           leg_rdata
);

  region_e              dec_region;
  logic [RAM_BANKS-1:0] dec_bank;
  logic                 dec_screen;

  shadow_region_decode #(
    .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .RAM_BANKS(RAM_BANKS),
    .SCR_LO(SCR_LO), .SCR_HI(SCR_HI)
  ) u_decode (
    .addr      (cpu_addr),
    .be        (cpu_be),
    .region    (dec_region),
    .bank_oh   (dec_bank),
    .in_screen (dec_screen)
  );

  shadow_seq #(
    .RAM_BANKS(RAM_BANKS), .WAW(WAW), .LEG_AW(LEG_AW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_waddr   (cpu_addr[BANK_AW-1:2]),
    .cpu_be      (cpu_be),
    .cpu_wdata   (cpu_wdata),
    .dec_region  (dec_region),
    .dec_bank    (dec_bank),
    .dec_screen  (dec_screen),
    .cpu_ack     (cpu_ack),
    .cpu_berr    (cpu_berr),
    .cpu_rdata   (cpu_rdata),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .ram_sel     (ram_sel),
    .ram_ack     (ram_ack),
    .ram_rdata   (ram_rdata),
    .flash_sel   (flash_sel),
    .flash_ack   (flash_ack),
    .flash_rdata (flash_rdata),
    .leg_strb    (leg_strb),
    .leg_we      (leg_we),
    .leg_addr    (leg_addr),
    .leg_wdata   (leg_wdata),
    .leg_ack     (leg_ack),
    .leg_rdata   (leg_rdata)
  );

endmodule

// File: tb/screen_shadow_decoder_tb.sv
module screen_shadow_decoder_tb;

  localparam int EV_RAM = 0, EV_FLASH = 1, EV_LEG = 2, EV_ACK = 3, EV_BERR = 4;
  localparam int RAM_LAT = 2, FLASH_LAT = 1, LEG_LAT = 3;

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] d;
    bit          chk_d;
    string       tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack, cpu_berr;
  logic [31:0] cpu_rdata;
  logic [19:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [2:0]  ram_sel;
  logic        ram_ack = 1'b0, flash_ack = 1'b0, leg_ack = 1'b0;
  logic [31:0] ram_rdata, flash_rdata;
  logic        flash_sel, leg_strb, leg_we;
  logic [19:0] leg_addr;
  logic [7:0]  leg_wdata, leg_rdata;

  int  checks = 0, errors = 0;
  int  ram_cnt = 0, flash_cnt = 0, leg_cnt = 0;
  bit  done = 1'b0;
  bit  excl_bad = 1'b0;
  ev_t exp_q[$];

  always #4 clk = ~clk;

  assign ram_rdata   = {12'hA50, mem_addr};
  assign flash_rdata = {12'hF1A, mem_addr};
  assign leg_rdata   = leg_addr[7:0] ^ 8'h3C;

  screen_shadow_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_berr(cpu_berr), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .ram_sel(ram_sel), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
    .flash_sel(flash_sel), .flash_ack(flash_ack), .flash_rdata(flash_rdata),
    .leg_strb(leg_strb), .leg_we(leg_we), .leg_addr(leg_addr), .leg_wdata(leg_wdata),
    .leg_ack(leg_ack), .leg_rdata(leg_rdata)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d,
                      input bit chk_d, input string tag);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.chk_d = chk_d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] d);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R10", $sformatf("unexpected event kind %0d", kind), a, 32'h0);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.tag, "event kind", 32'(kind), 32'(e.kind));
      if (e.kind == kind) begin
        check(a == e.a, e.tag, $sformatf("kind %0d address/control", kind), a, e.a);
        if (e.chk_d) check(d == e.d, e.tag, $sformatf("kind %0d data", kind), d, e.d);
      end
    end
  endtask

  // Target models and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_ack && cpu_berr) excl_bad = 1'b1;
      if (($countones({|ram_sel, flash_sel, leg_strb})) > 1) excl_bad = 1'b1;
      if (ram_ack) begin
        ram_ack = 1'b0; ram_cnt = 0;
      end else if (|ram_sel) begin
        if (ram_cnt == 0) observe(EV_RAM, {1'b0, ram_sel, mem_we, mem_be, 3'b0, mem_addr},
                                  mem_we ? mem_wdata : 32'h0);
        ram_cnt++;
        if (ram_cnt == RAM_LAT) ram_ack = 1'b1;
      end
      if (flash_ack) begin
        flash_ack = 1'b0; flash_cnt = 0;
      end else if (flash_sel) begin
        if (flash_cnt == 0) observe(EV_FLASH, {11'b0, mem_we, mem_addr},
                                    mem_we ? mem_wdata : 32'h0);
        flash_cnt++;
        if (flash_cnt == FLASH_LAT) flash_ack = 1'b1;
      end
      if (leg_ack) begin
        check(!leg_strb, "R8", "strobe low after byte ack", 32'(leg_strb), 32'h0);
        leg_ack = 1'b0; leg_cnt = 0;
      end else if (leg_strb) begin
        if (leg_cnt == 0) observe(EV_LEG, {11'b0, leg_we, leg_addr}, {24'b0, leg_wdata});
        leg_cnt++;
        if (leg_cnt == LEG_LAT) leg_ack = 1'b1;
      end
      if (cpu_ack)  observe(EV_ACK, 32'h0, cpu_rdata);
      if (cpu_berr) observe(EV_BERR, 32'h0, 32'h0);
    end
  end

  task automatic access(input logic we, input logic [23:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input string tag);
    logic [31:0] rexp;
    logic [2:0]  oh;
    int          n;
    rexp = 32'h0;
    if (be == 4'b0000) begin
      push(EV_BERR, 32'h0, 32'h0, 1'b0, tag);
    end else if (addr < 24'hC00000) begin
      oh = 3'b001 << addr[23:22];
      push(EV_RAM, {1'b0, oh, we, be, 3'b0, addr[21:2]}, we ? wd : 32'h0, we, tag);
      if (we && addr >= 24'h020000 && addr <= 24'h027FFF)
        for (int k = 0; k < 4; k++)
          if (be[3-k]) push(EV_LEG, {11'b0, 1'b1, addr[19:2], 2'(k)},
                            {24'b0, wd[8*(3-k) +: 8]}, 1'b1, tag);
      push(EV_ACK, 32'h0, {12'hA50, addr[21:2]}, !we, tag);
    end else if (addr < 24'hE00000) begin
      push(EV_FLASH, {11'b0, we, addr[21:2]}, we ? wd : 32'h0, we, tag);
      push(EV_ACK, 32'h0, {12'hF1A, addr[21:2]}, !we, tag);
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (be[3-k]) begin
          push(EV_LEG, {11'b0, we, addr[19:2], 2'(k)},
               we ? {24'b0, wd[8*(3-k) +: 8]} : 32'h0, we, tag);
          if (!we) rexp[8*(3-k) +: 8] = {addr[7:2], 2'(k)} ^ 8'h3C;
        end
      end
      push(EV_ACK, 32'h0, rexp, !we, tag);
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(cpu_ack || cpu_berr) && n < 200);
    cpu_req = 1'b0;
    check(n < 200, tag, "access completes", 32'(n), 32'd200);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ram_sel == 3'b000 && !flash_sel && !leg_strb && !cpu_ack && !cpu_berr,
          "R1", "outputs quiet in reset", {27'b0, ram_sel, flash_sel, leg_strb}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ram_sel == 3'b000 && !flash_sel && !leg_strb && !cpu_ack && !cpu_berr,
          "R1", "outputs quiet after reset", {27'b0, ram_sel, flash_sel, leg_strb}, 32'h0);

    access(1'b1, 24'h000100, 4'b1111, 32'h11223344, "R2");
    access(1'b0, 24'h400010, 4'b1111, 32'h0,        "R2");
    access(1'b0, 24'hBFFFFC, 4'b0011, 32'h0,        "R2");
    access(1'b0, 24'hC00008, 4'b1111, 32'h0,        "R3");
    access(1'b1, 24'hDFFFF0, 4'b1100, 32'hCAFEF00D, "R3");
    access(1'b0, 24'hE20004, 4'b1111, 32'h0,        "R4");
    access(1'b0, 24'hF20010, 4'b0101, 32'h0,        "R4");
    access(1'b1, 24'hE00000, 4'b1001, 32'hA1B2C3D4, "R7");
    access(1'b0, 24'h020000, 4'b1111, 32'h0,        "R5");
    access(1'b1, 24'h020004, 4'b1111, 32'hDEADBEEF, "R6");
    access(1'b1, 24'h027FFC, 4'b0110, 32'h55667788, "R7");
    access(1'b1, 24'h020000, 4'b0001, 32'h000000AB, "R9");
    access(1'b1, 24'h028000, 4'b1111, 32'h01020304, "R10");
    access(1'b1, 24'h01FFFC, 4'b1111, 32'h05060708, "R10");
    access(1'b1, 24'h020010, 4'b0000, 32'h12345678, "R11");
    access(1'b0, 24'hE00040, 4'b0000, 32'h0,        "R11");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "all expected events seen", 32'(exp_q.size()), 32'h0);
    check(!excl_bad, "R12", "ack/berr and target exclusivity", 32'(excl_bad), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule